// File: doc/BRIEF.md
# Fractional-N Division Sequencer

This block sits beside the feedback counter of a fractional-N PLL and tells it, once per reference-clock cycle, which whole number to divide by next. Software or pins supply an integer ratio and an 18-bit fraction. The block issues a stream of integer divide values whose long-run mean is the integer plus (fraction + 0.5) / 2^18. The extra half step means the fractional path always toggles, so it never settles into one constant integer. A third-order cascade of three first-order accumulators (MASH 1-1-1) spreads the quantisation error toward high offsets, where the loop filter removes it.

An integer-only control drops the fraction, so the sequencer emits the plain integer every cycle. Clearing the enable empties every accumulator, and the output then holds the integer with the strobe low. All settings pass through one capture register before use. Each emitted value is therefore built entirely from one sampled set of settings.

Top module: `frac_div_seq`

## Requirements
- R1: While reset is low at a clock edge, the following cycle shows `div_valid` = 0 and `div_val` = 0.
- R2: Settings present before clock edge k are captured at edge k and first reach `div_val` at edge k+1. An output never combines the integer of one cycle with the fraction of another.
- R3: When `en` is sampled low, two edges later `div_valid` is 0 and `div_val` equals the integer sampled at that time. All accumulators and carry delays are cleared, so the next enabled run starts from zero state.
- R4: When `en` is high and `int_only` is high, two edges later `div_valid` is 1 and `div_val` equals the sampled integer. The fraction has no effect.
- R5: In fractional mode, every `div_val` lies between the sampled integer minus 3 and the sampled integer plus 4, inclusive.
- R6: The accumulator increment is 2*`div_frac`+1 on a 19-bit modulus. After k fractional outputs from a cleared state with constant settings, the sum of (`div_val` - integer) minus floor(k*(2*`div_frac`+1)/2^19) lies in [-1, 2].
- R7: Each fractional output equals the integer plus c1[n] + c2[n] - c2[n-1] + c3[n] - 2*c3[n-1] + c3[n-2]. Here ci is the carry out of stage i at cycle n. Stage 1 adds the increment, stage 2 adds the new residue of stage 1, and stage 3 adds the new residue of stage 2. All stages are modulo 2^19.
- R8: A change of the integer or the fraction during an enabled run does not clear the accumulators. The new increment applies from the first cycle in which it is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run the modulator; low clears the accumulators |
| int_only | input | 1 | Emit the integer only and ignore the fraction |
| div_int | input | 7 | Integer part of the division ratio |
| div_frac | input | 18 | Fractional part of the ratio, in units of 2^-18 |
| div_val | output | 8 | Instantaneous divide value for this reference cycle |
| div_valid | output | 1 | High when `div_val` comes from an enabled run |

## Verification
The range checks on `div_val` assume the integer part is at least 3 whenever the fractional path runs, so the lowest correction cannot wrap below zero. The stimulus keeps the integer between 3 and 127 in every fractional phase. The port-level checks for the disabled and integer-only cases assume the inputs have been stable for two edges inside reset-free time. The bench holds each setting for many cycles, except in the one phase that changes the settings in the middle of a run on purpose.

// File: rtl/frac_div_pkg.sv
// Shared types for the fractional division sequencer.
package frac_div_pkg;
    // Number of cascaded first-order stages in the noise shaper.
    localparam int MASH_ORDER = 3;
    // Signed correction: -3..+4 fits in four bits.
    typedef logic [3:0] corr_t;
endpackage

// File: rtl/frac_div_cfg.sv
// Settings capture register.
// Samples all control inputs together on each clock edge, so downstream
// logic sees one consistent set per cycle. Assumes a synchronous reset.
module frac_div_cfg #(
    parameter int INT_W  = 7,
    parameter int FRAC_W = 18,
    localparam int ACC_W = FRAC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             int_only,
    input  logic [INT_W-1:0] div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic             cfg_en,
    output logic             cfg_run,
    output logic [INT_W-1:0] cfg_mint,
    output logic [ACC_W-1:0] cfg_inc
);
    logic cfg_io;

    // Capture the settings; the increment carries the built-in half step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en   <= 1'b0;
            cfg_io   <= 1'b0;
            cfg_mint <= '0;
            cfg_inc  <= '0;
        end else begin
            cfg_en   <= en;
            cfg_io   <= int_only;
            cfg_mint <= div_int;
            cfg_inc  <= {div_frac, 1'b1};
        end
    end

    assign cfg_run = cfg_en && !cfg_io;
endmodule

// File: rtl/frac_div_acc_stage.sv
// One first-order accumulator stage.
// Adds the addend modulo 2^ACC_W and reports the carry and the new residue
// in the same cycle. Clears while clr is high.
module frac_div_acc_stage #(
    parameter int ACC_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] residue,
    output logic             carry
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   total;

    // Wide sum: the top bit is the overflow carry.
    always_comb begin
        total   = {1'b0, acc} + {1'b0, addend};
        carry   = total[ACC_W];
        residue = total[ACC_W-1:0];
    end

    // Keep the residue, or clear when the modulator is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc <= '0;
        else               acc <= residue;
    end
endmodule

// File: rtl/frac_div_mash.sv
// Third-order MASH 1-1-1 noise shaper.
// Three cascaded accumulators driven by the increment. Carries are combined
// through difference terms into a correction of -3..+4. Assumes run is low
// whenever the fraction must not contribute; the correction is then zero.
module frac_div_mash
    import frac_div_pkg::*;
#(
    parameter int ACC_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [ACC_W-1:0] inc,
    output corr_t            corr
);
    logic [ACC_W-1:0] addend [MASH_ORDER];
    logic [ACC_W-1:0] residue[MASH_ORDER];
    logic [MASH_ORDER-1:0] carry;
    logic c2_d1, c3_d1, c3_d2;
    logic [4:0] mix;

    for (genvar g = 0; g < MASH_ORDER; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign addend[g] = inc;
        end else begin : g_next
            assign addend[g] = residue[g-1];
        end
        frac_div_acc_stage #(.ACC_W(ACC_W)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (!run),
            .addend (addend[g]),
            .residue(residue[g]),
            .carry  (carry[g])
        );
    end

    // Delay the later-stage carries for the difference terms.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            c2_d1 <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
        end else begin
            c2_d1 <= carry[1];
            c3_d1 <= carry[2];
            c3_d2 <= c3_d1;
        end
    end

    // Combine the carries: c1 + (1-z)c2 + (1-z)^2 c3, modulo 32.
    always_comb begin
        mix = 5'(carry[0]) + 5'(carry[1]) - 5'(c2_d1) + 5'(carry[2])
              - (5'(c3_d1) << 1) + 5'(c3_d2);
        corr = run ? mix[3:0] : '0;
    end

    // The combined correction stays inside -3..+4 (R5).
    always_ff @(posedge clk) begin
        if (rst_n && run) begin
            assert_corr_span_R5: assert ($signed(corr) >= -4'sd3 && $signed(corr) <= 4'sd4)
                else $error("correction out of span");
        end
    end
endmodule

// File: rtl/frac_div_out.sv
// Output register.
// Adds the correction to the integer of the same captured cycle. Holds the
// plain integer when idle. Assumes mint >= 3 while run is high.
module frac_div_out
    import frac_div_pkg::*;
#(
    parameter int INT_W = 7,
    localparam int OUT_W = INT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             run,
    input  logic [INT_W-1:0] mint,
    input  corr_t            corr,
    output logic [OUT_W-1:0] div_val,
    output logic             div_valid
);
    logic [OUT_W:0] corr_x;
    logic [OUT_W:0] total;

    // Sign-extend the correction and form the divide value.
    always_comb begin
        corr_x = {{(OUT_W-3){corr[3]}}, corr};
        total  = {2'b00, mint} + corr_x;
    end

    // Register the value and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_val   <= '0;
            div_valid <= 1'b0;
        end else begin
            div_val   <= total[OUT_W-1:0];
            div_valid <= cfg_en;
        end
    end

    // Leaving reset shows the cleared state (R1).
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!div_valid && div_val == '0))
        else $error("outputs not cleared by reset");

    // Fractional output stays within -3..+4 of its own integer (R5).
    assert_val_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($signed({1'b0, div_val}) >= $signed({2'b00, $past(mint)}) - 3 &&
                 $signed({1'b0, div_val}) <= $signed({2'b00, $past(mint)}) + 4))
        else $error("divide value outside span");
endmodule

// File: rtl/frac_div_seq.sv
// Fractional-N division sequencer, top level.
// Captures the settings, runs a MASH 1-1-1 modulator on the 19-bit
// increment 2*frac+1 and emits one integer divide value per reference cycle.
// Latency from pins to div_val is two edges.
module frac_div_seq
    import frac_div_pkg::*;
#(
    parameter int INT_W  = 7,
    parameter int FRAC_W = 18,
    localparam int ACC_W = FRAC_W + 1,
    localparam int OUT_W = INT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              int_only,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic [OUT_W-1:0]  div_val,
    output logic              div_valid
);
    logic             cfg_en;
    logic             cfg_run;
    logic [INT_W-1:0] cfg_mint;
    logic [ACC_W-1:0] cfg_inc;
    corr_t            corr;

    frac_div_cfg #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .en(en), .int_only(int_only),
        .div_int(div_int), .div_frac(div_frac),
        .cfg_en(cfg_en), .cfg_run(cfg_run), .cfg_mint(cfg_mint), .cfg_inc(cfg_inc)
    );

    frac_div_mash #(.ACC_W(ACC_W)) u_mash (
        .clk(clk), .rst_n(rst_n), .run(cfg_run), .inc(cfg_inc), .corr(corr)
    );

    frac_div_out #(.INT_W(INT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .run(cfg_run),
        .mint(cfg_mint), .corr(corr), .div_val(div_val), .div_valid(div_valid)
    );

    // Disabled: strobe low and plain integer two edges later (R3).
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ##1 (!div_valid && div_val == OUT_W'($past(div_int, 2))))
        else $error("idle output wrong");

    // Integer-only: strobe high and plain integer two edges later (R4).
    assert_int_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && int_only) |=> ##1 (div_valid && div_val == OUT_W'($past(div_int, 2))))
        else $error("integer-only output wrong");
endmodule

// File: tb/tb_frac_div_seq.sv
module tb_frac_div_seq;
    localparam int  A = 19;
    localparam longint MOD = longint'(1) << A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        int_only = 1'b0;
    logic [6:0]  div_int = 7'd0;
    logic [17:0] div_frac = 18'd0;
    logic [7:0]  div_val;
    logic        div_valid;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;
    string tag = "R1";

    frac_div_seq dut (
        .clk(clk), .rst_n(rst_n), .en(en), .int_only(int_only),
        .div_int(div_int), .div_frac(div_frac),
        .div_val(div_val), .div_valid(div_valid)
    );

    always #2 clk = ~clk;

    // Behavioural reference state.
    bit     m_en, m_io;
    longint m_mint, m_inc;
    longint a1, a2, a3;
    int     c2d, c3d, c3dd;
    longint exp_val, exp_mint, exp_inc;
    bit     exp_valid, exp_run;
    // Running-sum tracking for the average requirement.
    longint r6_k, r6_sum, r6_inc;
    bit     r6_live;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cycles);
        end
    endtask

    // Model: produce the expected output of this edge, then capture pins.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_io = 0; m_mint = 0; m_inc = 0;
            a1 = 0; a2 = 0; a3 = 0; c2d = 0; c3d = 0; c3dd = 0;
            exp_val = 0; exp_valid = 0; exp_run = 0; exp_mint = 0; exp_inc = 0;
        end else begin
            if (m_en && !m_io) begin
                longint s1, s2, s3;
                int c1, c2, c3, corr;
                s1 = a1 + m_inc; c1 = int'(s1 / MOD); a1 = s1 % MOD;
                s2 = a2 + a1;    c2 = int'(s2 / MOD); a2 = s2 % MOD;
                s3 = a3 + a2;    c3 = int'(s3 / MOD); a3 = s3 % MOD;
                corr = c1 + c2 - c2d + c3 - 2 * c3d + c3dd;
                c3dd = c3d; c3d = c3; c2d = c2;
                exp_val = m_mint + corr;
                exp_run = 1;
            end else begin
                a1 = 0; a2 = 0; a3 = 0; c2d = 0; c3d = 0; c3dd = 0;
                exp_val = m_mint;
                exp_run = 0;
            end
            exp_valid = m_en;
            exp_mint = m_mint;
            exp_inc = m_inc;
            m_en = en; m_io = int_only; m_mint = div_int;
            m_inc = 2 * longint'(div_frac) + 1;
        end
    end

    // Compare just after every edge.
    always @(posedge clk) begin
        #1;
        if (!done) begin
            cycles++;
            chk(div_val == exp_val[7:0], tag, div_val, exp_val);
            chk(div_valid == exp_valid, tag, div_valid, exp_valid);
            if (exp_run) begin
                longint d, err;
                d = longint'(div_val) - exp_mint;
                chk(d >= -3 && d <= 4, "R5", d, 0);
                if (r6_k == 0) begin
                    r6_inc = exp_inc;
                    r6_live = 1;
                end
                if (exp_inc != r6_inc) r6_live = 0;
                r6_k++;
                r6_sum += d;
                if (r6_live) begin
                    err = r6_sum - ((r6_k * r6_inc) >> A);
                    chk(err >= -1 && err <= 2, "R6", err, 0);
                end
            end else begin
                r6_k = 0; r6_sum = 0; r6_live = 1;
            end
        end
    end

    task automatic phase(input bit e, input bit io, input int mi, input int fr,
                         input int n, input string t);
        @(negedge clk);
        en = e; int_only = io; div_int = 7'(mi); div_frac = 18'(fr);
        tag = t;
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        r6_k = 0; r6_sum = 0; r6_inc = 0; r6_live = 1;
        // R1: reset state.
        repeat (4) @(negedge clk);
        chk(div_val == 8'd0 && !div_valid, "R1", div_val, 0);
        rst_n = 1'b1;
        // R3: disabled holds the integer with strobe low.
        phase(0, 0, 10, 5000, 20, "R3");
        // R2: two-edge latency and no mixing.
        @(negedge clk);
        div_int = 7'd20;
        @(negedge clk);
        chk(div_val == 8'd10, "R2", div_val, 10);
        @(negedge clk);
        chk(div_val == 8'd20, "R2", div_val, 20);
        // R4: integer-only ignores the fraction.
        phase(1, 1, 37, 200000, 200, "R4");
        phase(1, 1, 127, 3, 200, "R4");
        // R7 and R6: fractional patterns from a cleared state.
        phase(0, 0, 50, 0, 5, "R3");
        phase(1, 0, 50, 0, 20000, "R7");
        phase(0, 0, 50, 0, 5, "R3");
        phase(1, 0, 3, 1, 15000, "R7");
        phase(0, 0, 3, 1, 5, "R3");
        phase(1, 0, 100, 131072, 15000, "R7");
        phase(0, 0, 100, 0, 5, "R3");
        phase(1, 0, 127, 262143, 15000, "R7");
        phase(0, 0, 64, 0, 5, "R3");
        phase(1, 0, 64, 12345, 20000, "R7");
        // R8: settings change during a run, accumulators kept.
        phase(1, 0, 64, 200001, 3000, "R8");
        phase(1, 0, 9, 77, 3000, "R8");
        phase(1, 1, 9, 77, 50, "R4");
        phase(1, 0, 90, 99999, 5000, "R8");
        phase(0, 0, 42, 99999, 10, "R3");
        // Reset in the middle of a run.
        @(negedge clk);
        rst_n = 1'b0;
        tag = "R1";
        repeat (3) @(negedge clk);
        chk(div_val == 8'd0 && !div_valid, "R1", div_val, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule